// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status flags of a serial port: transmit data empty, receive data full, receive parity error, transmit end and the last received multiprocessor bit. The receiver and transmitter datapaths send it one-cycle event strobes. The CPU reads all flags through a read port and clears the clearable ones through a write port. The block also drives halt signals back to the datapaths. A received character that has a parity error is still handed to the receive data register through `rx_load`. In that case the receive-full flag stays low and further reception stops until software clears the error.

The three clearable flags (transmit empty, receive full, parity error) each have an arm latch. A CPU read that returns 1 for a flag sets that flag's arm latch. The next CPU write releases every arm latch. A write of 0 clears a flag only if that flag's latch was armed. A hardware set event wins over a software clear in the same cycle.

The transmit-end flag comes from a three-state machine:
- `TXE_DISABLED`: transmit is off and the flag reads 1.
- `TXE_ENDED`: the last character is done and the flag reads 1.
- `TXE_SENDING`: a character is in flight and the flag reads 0.

The transitions are:
- From any state, `tx_en` low or `standby` goes to `TXE_DISABLED`.
- `TXE_DISABLED` goes to `TXE_ENDED` when `tx_en` is high.
- `TXE_ENDED` goes to `TXE_SENDING` on a clear event: a software clear of transmit-empty or a DMA write. This move is blocked when a last-bit-with-empty event occurs in the same cycle.
- `TXE_SENDING` goes to `TXE_ENDED` when the last bit is shifted out while transmit-empty is 1.

Top module: `serial_status_flags`

## Requirements
- R1: After reset, and in any cycle following one with `standby` high, the flags read tx_empty=1, rx_full=0, par_err=0, tx_end=1, mp_bit=0. `cpu_rdata` bit 0 is tx_empty, bit 1 rx_full, bit 2 par_err, bit 3 tx_end and bit 4 mp_bit.
- R2: A `cpu_wr` with 0 in bit i of `cpu_wdata` clears clearable flag i (bit 0 tx_empty, bit 1 rx_full, bit 2 par_err). It does so only if a `cpu_rd` since the previous write returned that flag as 1. A write without such a read, or a write of 1, leaves the flag unchanged.
- R3: An accepted character (`rx_done` while `rx_en`=1 and par_err=0) pulses `rx_load` in the same cycle. If `parity_en`=1 and the number of 1s in `rx_data` plus `rx_par_bit` is odd with `parity_odd`=0, or even with `parity_odd`=1, par_err is set and rx_full is not. Otherwise rx_full is set.
- R4: While par_err=1, `rx_halt`=1 and `rx_done` is ignored (no `rx_load`, no flag change). `tx_halt` is 1 exactly when par_err=1 and `sync_mode`=1.
- R5: With `rx_en`=0, `rx_done` is ignored. Lowering `rx_en` leaves par_err and mp_bit unchanged.
- R6: tx_end sets when `tx_last_bit` pulses while tx_empty=1. With tx_empty=0, `tx_last_bit` leaves tx_end at 0.
- R7: `tdr_taken` sets tx_empty. `dma_tdr_wr` clears tx_empty and tx_end. A software clear of tx_empty (R2) also clears tx_end.
- R8: While `tx_en`=0, tx_end reads 1 from the next cycle on.
- R9: An accepted character with `mp_format`=1 and `sync_mode`=0 copies `rx_mp_bit` into mp_bit. Otherwise mp_bit holds.
- R10: A set event and a qualifying software clear of the same flag in one cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby | input | 1 | Forces all flags to reset values |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| sync_mode | input | 1 | 1 = synchronous mode |
| mp_format | input | 1 | Multiprocessor format selected |
| parity_en | input | 1 | Parity checking on |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_done | input | 1 | End-of-character strobe |
| rx_data | input | DATA_W | Received data bits |
| rx_par_bit | input | 1 | Received parity bit |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| tdr_taken | input | 1 | Shifter took transmit data |
| tx_last_bit | input | 1 | Last bit of a character shifted out |
| dma_tdr_wr | input | 1 | DMA wrote transmit data |
| cpu_rd | input | 1 | CPU status read |
| cpu_wr | input | 1 | CPU status write |
| cpu_wdata | input | 3 | Write data for the clearable flags |
| cpu_rdata | output | 5 | Flag read value |
| tx_empty | output | 1 | Transmit data empty |
| rx_full | output | 1 | Receive data full |
| par_err | output | 1 | Parity error |
| tx_end | output | 1 | Transmit end |
| mp_bit | output | 1 | Last multiprocessor bit |
| rx_halt | output | 1 | Receiver halted |
| tx_halt | output | 1 | Transmitter halted |
| rx_load | output | 1 | Load receive data register |

## Verification
Characters are sent with even and with odd parity, each with a correct and with a wrong parity bit. This separates a correct parity sense from an inverted one and from a check that ignores the parity bit. Clear writes are tried in four ways: without a prior read, with a written 1, after a proper read, and in the same cycle as a hardware set. These cases separate the arm rule from plain write-0 clearing and show set priority. The last-bit strobe is given with transmit-empty both 0 and 1, and transmit-end is also exercised through DMA writes, enable removal and standby, so every state-machine transition is visited.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int FLAG_W = 5;
    localparam int CLR_N  = 3;
    localparam int B_TXE  = 0;
    localparam int B_RXF  = 1;
    localparam int B_PER  = 2;
    localparam int B_TEND = 3;
    localparam int B_MPB  = 4;

    typedef enum logic [1:0] {
        TXE_DISABLED = 2'd0,
        TXE_SENDING  = 2'd1,
        TXE_ENDED    = 2'd2
    } txend_state_e;
endpackage

// File: rtl/sts_flag_cell.sv
module sts_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic sw_clr_o
);
    logic flag_q;
    logic arm_q;

    assign sw_clr_o = wr_i && arm_q && !wbit_i;
    assign flag_o   = flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= RST_VAL;
        end else if (standby) begin
            flag_q <= RST_VAL;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (sw_clr_o || hw_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (standby) begin
            arm_q <= 1'b0;
        end else if (wr_i) begin
            arm_q <= rd_i && flag_q;
        end else if (rd_i && flag_q) begin
            arm_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sts_rx_eval.sv
module sts_rx_eval #(
    parameter int DATA_W = 8
) (
    input  logic              rx_done,
    input  logic              rx_en,
    input  logic              halted,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    output logic              accept_o,
    output logic              perr_o
);
    logic ones_odd;

    always_comb begin
        ones_odd = (^rx_data) ^ rx_par_bit;
        accept_o = rx_done && rx_en && !halted;
        perr_o   = parity_en && (ones_odd != parity_odd);
    end
endmodule

// File: rtl/sts_txend_fsm.sv
module sts_txend_fsm
    import sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic tx_en,
    input  logic last_bit,
    input  logic tx_empty,
    input  logic clr_evt,
    output logic tend_o
);
    txend_state_e state_q;
    txend_state_e state_n;
    logic         end_evt;

    assign end_evt = last_bit && tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TXE_DISABLED;
        end else if (standby) begin
            state_q <= TXE_DISABLED;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        if (!tx_en) begin
            state_n = TXE_DISABLED;
        end else begin
            unique case (state_q)
                TXE_DISABLED: state_n = TXE_ENDED;
                TXE_SENDING:  if (end_evt) state_n = TXE_ENDED;
                TXE_ENDED:    if (clr_evt && !end_evt) state_n = TXE_SENDING;
                default:      state_n = TXE_DISABLED;
            endcase
        end
    end

    always_comb begin
        tend_o = 1'b1;
        unique case (state_q)
            TXE_SENDING: tend_o = 1'b0;
            default:     tend_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
    import sts_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              mp_format,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_mp_bit,
    input  logic              tdr_taken,
    input  logic              tx_last_bit,
    input  logic              dma_tdr_wr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CLR_N-1:0]  cpu_wdata,
    output logic [FLAG_W-1:0] cpu_rdata,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              par_err,
    output logic              tx_end,
    output logic              mp_bit,
    output logic              rx_halt,
    output logic              tx_halt,
    output logic              rx_load
);
    localparam logic [CLR_N-1:0] CLR_RST = CLR_N'(1) << B_TXE;

    logic [CLR_N-1:0] set_v;
    logic [CLR_N-1:0] hw_clr_v;
    logic [CLR_N-1:0] flag_v;
    logic [CLR_N-1:0] sw_clr_v;
    logic             accept;
    logic             perr_now;
    logic             mpb_q;

    sts_rx_eval #(.DATA_W(DATA_W)) u_rx_eval (
        .rx_done    (rx_done),
        .rx_en      (rx_en),
        .halted     (flag_v[B_PER]),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .rx_data    (rx_data),
        .rx_par_bit (rx_par_bit),
        .accept_o   (accept),
        .perr_o     (perr_now)
    );

    always_comb begin
        set_v           = '0;
        hw_clr_v        = '0;
        set_v[B_TXE]    = tdr_taken;
        set_v[B_RXF]    = accept && !perr_now;
        set_v[B_PER]    = accept && perr_now;
        hw_clr_v[B_TXE] = dma_tdr_wr;
    end

    for (genvar i = 0; i < CLR_N; i++) begin : g_cell
        sts_flag_cell #(.RST_VAL(CLR_RST[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .standby  (standby),
            .set_i    (set_v[i]),
            .hw_clr_i (hw_clr_v[i]),
            .rd_i     (cpu_rd),
            .wr_i     (cpu_wr),
            .wbit_i   (cpu_wdata[i]),
            .flag_o   (flag_v[i]),
            .sw_clr_o (sw_clr_v[i])
        );
    end

    sts_txend_fsm u_txend (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .tx_en    (tx_en),
        .last_bit (tx_last_bit),
        .tx_empty (flag_v[B_TXE]),
        .clr_evt  (sw_clr_v[B_TXE] || dma_tdr_wr),
        .tend_o   (tx_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpb_q <= 1'b0;
        end else if (standby) begin
            mpb_q <= 1'b0;
        end else if (accept && mp_format && !sync_mode) begin
            mpb_q <= rx_mp_bit;
        end
    end

    always_comb begin
        tx_empty          = flag_v[B_TXE];
        rx_full           = flag_v[B_RXF];
        par_err           = flag_v[B_PER];
        mp_bit            = mpb_q;
        rx_halt           = flag_v[B_PER];
        tx_halt           = flag_v[B_PER] && sync_mode;
        rx_load           = accept;
        cpu_rdata         = '0;
        cpu_rdata[B_TXE]  = flag_v[B_TXE];
        cpu_rdata[B_RXF]  = flag_v[B_RXF];
        cpu_rdata[B_PER]  = flag_v[B_PER];
        cpu_rdata[B_TEND] = tx_end;
        cpu_rdata[B_MPB]  = mpb_q;
    end
endmodule

// File: rtl/sts_flag_checker.sv
module sts_flag_checker (
    input logic clk,
    input logic rst_n,
    input logic standby,
    input logic tx_en,
    input logic tx_last_bit,
    input logic dma_tdr_wr,
    input logic cpu_wr,
    input logic tx_empty,
    input logic rx_full,
    input logic par_err,
    input logic tx_end,
    input logic mp_bit,
    input logic rx_halt,
    input logic rx_load
);
    a_r4_no_load_halted: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halt |-> !rx_load);

    a_r3_err_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> !$rose(rx_full));

    a_r8_tx_off_end: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_end);

    a_r6_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> ($past(tx_last_bit && tx_empty) || !$past(tx_en) || $past(standby)));

    a_r7_end_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_end) |-> ($past(cpu_wr) || $past(dma_tdr_wr)));

    a_r9_mpb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_load && !standby) |=> $stable(mp_bit));
endmodule

bind serial_status_flags sts_flag_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .tx_en       (tx_en),
    .tx_last_bit (tx_last_bit),
    .dma_tdr_wr  (dma_tdr_wr),
    .cpu_wr      (cpu_wr),
    .tx_empty    (tx_empty),
    .rx_full     (rx_full),
    .par_err     (par_err),
    .tx_end      (tx_end),
    .mp_bit      (mp_bit),
    .rx_halt     (rx_halt),
    .rx_load     (rx_load)
);

// File: tb/serial_status_flags_tb_top.sv
module serial_status_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 0, rx_en = 0, tx_en = 0, sync_mode = 0, mp_format = 0;
    logic       parity_en = 0, parity_odd = 0, rx_done = 0, rx_par_bit = 0, rx_mp_bit = 0;
    logic       tdr_taken = 0, tx_last_bit = 0, dma_tdr_wr = 0, cpu_rd = 0, cpu_wr = 0;
    logic [7:0] rx_data = '0;
    logic [2:0] cpu_wdata = '0;
    logic [4:0] cpu_rdata;
    logic       tx_empty, rx_full, par_err, tx_end, mp_bit, rx_halt, tx_halt, rx_load;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    serial_status_flags dut_i (.*);

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: inputs already set at negedge; push expectation at the edge
    task automatic tick(input string tag, input logic [4:0] exp);
        @(posedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rx_done = 0; tdr_taken = 0; tx_last_bit = 0; dma_tdr_wr = 0;
        cpu_rd = 0; cpu_wr = 0; standby = 0;
    endtask

    task automatic rd_arm(input string tag, input logic [4:0] exp);
        cpu_rd = 1;
        tick(tag, exp);
    endtask

    task automatic wr(input logic [2:0] d, input string tag, input logic [4:0] exp);
        cpu_wr = 1; cpu_wdata = d;
        tick(tag, exp);
    endtask

    task automatic rx(input logic [7:0] d, input logic p, input logic load_exp,
                      input string tag, input logic [4:0] exp);
        rx_data = d; rx_par_bit = p; rx_done = 1;
        #2 chk({tag, " rx_load"}, {4'b0, rx_load}, {4'b0, load_exp});
        tick(tag, exp);
    endtask

    // monitor: compare flags mid-cycle after each edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (exp_q.size() > 0) chk(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
        end
    end

    initial begin
        #4_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // expected bit order {mp_bit, tx_end, par_err, rx_full, tx_empty}
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1 chk("R1 reset", cpu_rdata, 5'b01001);
        @(negedge clk);
        tx_en = 1; rx_en = 1;
        tick("R1 enable", 5'b01001);
        // R2 arm rule
        wr(3'b110, "R2 unarmed write", 5'b01001);
        rd_arm("R2 read", 5'b01001);
        wr(3'b111, "R2 write one", 5'b01001);
        rd_arm("R2 read", 5'b01001);
        wr(3'b110, "R2 R7 clear tx_empty", 5'b00000);
        // R6, R7
        tx_last_bit = 1; tick("R6 last bit not empty", 5'b00000);
        tdr_taken = 1;   tick("R7 taken", 5'b00001);
        tx_last_bit = 1; tick("R6 end set", 5'b01001);
        dma_tdr_wr = 1;  tick("R7 dma", 5'b00000);
        // R10 on tx_empty
        tdr_taken = 1; tick("R7 taken", 5'b00001);
        rd_arm("R10 read", 5'b00001);
        tdr_taken = 1; cpu_wr = 1; cpu_wdata = 3'b110;
        tick("R10 set wins", 5'b00001);
        // R8
        tx_last_bit = 1; tick("R6 end set", 5'b01001);
        rd_arm("R2 read", 5'b01001);
        wr(3'b110, "R2 clear", 5'b00000);
        tx_en = 0; tick("R8 tx off", 5'b01000);
        dma_tdr_wr = 1; tick("R8 held off", 5'b01000);
        tx_en = 1; tick("R8 re-enable", 5'b01000);
        // R3 even parity
        parity_en = 1; parity_odd = 0;
        rx(8'h03, 1'b0, 1'b1, "R3 even ok", 5'b01010);
        rd_arm("R2 read", 5'b01010);
        wr(3'b101, "R2 clear rx_full", 5'b01000);
        rx(8'h07, 1'b0, 1'b1, "R3 even err", 5'b01100);
        #1 chk("R4 rx_halt", {4'b0, rx_halt}, 5'b00001);
        chk("R4 tx_halt async", {4'b0, tx_halt}, 5'b00000);
        sync_mode = 1;
        #1 chk("R4 tx_halt sync", {4'b0, tx_halt}, 5'b00001);
        sync_mode = 0;
        rx(8'h03, 1'b0, 1'b0, "R4 ignored while halted", 5'b01100);
        // R5
        rx_en = 0; tick("R5 rx off keeps par_err", 5'b01100);
        rd_arm("R2 read", 5'b01100);
        wr(3'b011, "R2 clear par_err", 5'b01000);
        rx(8'h07, 1'b0, 1'b0, "R5 ignored when off", 5'b01000);
        // R3 odd parity
        rx_en = 1; parity_odd = 1;
        rx(8'h01, 1'b0, 1'b1, "R3 odd ok", 5'b01010);
        rx(8'h01, 1'b1, 1'b1, "R3 odd err", 5'b01110);
        rd_arm("R2 read", 5'b01110);
        wr(3'b001, "R2 clear both", 5'b01000);
        // R9
        parity_en = 0; mp_format = 1; rx_mp_bit = 1;
        rx(8'h55, 1'b0, 1'b1, "R9 capture", 5'b11010);
        rx_en = 0; tick("R5 R9 rx off keeps mp", 5'b11010);
        rd_arm("R2 read", 5'b11010);
        wr(3'b101, "R2 clear rx_full", 5'b11000);
        rx_en = 1; mp_format = 0; rx_mp_bit = 0;
        rx(8'h00, 1'b0, 1'b1, "R9 no mp format", 5'b11010);
        mp_format = 1; sync_mode = 1;
        rx(8'h00, 1'b0, 1'b1, "R9 sync mode", 5'b11010);
        sync_mode = 0;
        // R10 on rx_full
        rd_arm("R10 read", 5'b11010);
        cpu_wr = 1; cpu_wdata = 3'b101; rx_data = 8'h00; rx_done = 1; rx_mp_bit = 1;
        tick("R10 rx set wins", 5'b11010);
        // R1 standby
        standby = 1; tick("R1 standby", 5'b01001);
        tick("R1 after standby", 5'b01001);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule